// File: doc/BRIEF.md
# Tile Message Network Interface

This block sits between the single task hosted on one tile of a packet-switched on-chip network and that network. A task sends a message by naming a logical task number and a payload length and then streaming the payload words. The interface looks the logical number up in a translation table and emits one header flit carrying the physical tile address, followed by the payload. Because peers only ever name logical numbers, a task can be moved to another tile, or to the processor, without any of its peers changing. Tasks that run on the processor are reached by mapping their logical number to the address of the tile that bridges to the processor.

A host keeps the table current through a small write port whenever it places a task on a tile or removes it. The interface runs no placement or routing algorithm of its own. On the receive side, the interface takes packets from the network, keeps those addressed to its own tile, strips the header and passes the payload and the sender's logical number to the task. All task-side and network-side streams use valid/ready handshakes.

Top module: `tile_msg_nif`

## Requirements
- R1: After reset, net_out_valid and rx_valid are 0, both error flags are 0, msg_ready is 1, and every table entry is disabled, so a message to any logical number is dropped until the host enables its entry.
- R2: For a message to a logical number whose entry is enabled, the block emits one header flit followed by the msg_len payload words in order and unchanged. Header layout: bits [3:0] payload length, bits [7:4] task_id, bits [9:8] the physical address from the table, bits [31:10] zero.
- R3: A message to a disabled entry is still accepted and its msg_len payload words are consumed from the task, but no flit leaves on the network and err_unroutable is set.
- R4: err_unroutable and err_misroute stay set until err_clr is high at a clock edge; when a new error and err_clr coincide, the flag ends up set.
- R5: A table write (cfg_we with cfg_idx, cfg_en, cfg_phys) is used by every message accepted at a later clock edge; writing cfg_en=0 removes the mapping; a write that lands while a packet is in flight leaves that packet's header unchanged.
- R6: An incoming packet whose header bits [9:8] equal tile_id has its payload passed to the task in order, with rx_src equal to header bits [7:4] and rx_last high on the final word only.
- R7: An incoming packet whose header bits [9:8] differ from tile_id is consumed in full, delivers nothing to the task and sets err_misroute.
- R8: While net_out_ready is low the outgoing flit stays valid and unchanged, and payload is taken from the network only as fast as rx_ready allows, with no word lost or repeated.
- R9: A message of length 0 produces a header flit only; an incoming packet of length 0 addressed to this tile produces no task beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_id | input | 2 | Physical address of this tile |
| task_id | input | 4 | Logical number of the hosted task, written into headers |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Logical number of the entry written |
| cfg_en | input | 1 | Entry enable value written |
| cfg_phys | input | 2 | Physical address value written |
| err_clr | input | 1 | Clears both error flags |
| err_unroutable | output | 1 | Sticky: a message named a disabled entry |
| err_misroute | output | 1 | Sticky: a packet for another tile arrived |
| msg_valid | input | 1 | Message descriptor valid |
| msg_ready | output | 1 | Descriptor accepted |
| msg_dest | input | 4 | Logical destination |
| msg_len | input | 4 | Payload word count, 0 to 15 |
| tx_valid | input | 1 | Outgoing payload word valid |
| tx_ready | output | 1 | Outgoing payload word taken |
| tx_data | input | 32 | Outgoing payload word |
| net_out_valid | output | 1 | Flit to network valid |
| net_out_ready | input | 1 | Network accepts flit |
| net_out_data | output | 32 | Flit to network |
| net_in_valid | input | 1 | Flit from network valid |
| net_in_ready | output | 1 | Flit from network taken |
| net_in_data | input | 32 | Flit from network |
| rx_valid | output | 1 | Payload word to task valid |
| rx_ready | input | 1 | Task accepts word |
| rx_data | output | 32 | Payload word to task |
| rx_src | output | 4 | Logical number of the sender |
| rx_last | output | 1 | Final word of the packet |

## Verification
The send path is swept over all sixteen logical numbers with a table in which a fixed arithmetic pattern enables some entries and spreads the rest over the four physical addresses, each message length equal to its number, so enabled, disabled, empty and full-length messages all appear and a wrong lookup index or a miscounted length shows as a header or word-count mismatch. The receive path is swept over every destination address against a fixed tile address with lengths 0, 1, 7 and 15, which separates delivery from discard. A second pass repeats both paths with irregular network and task backpressure to expose held or lost words, and dedicated cases cover a table write during a packet, entry removal, and an error coinciding with a clear.

// File: rtl/tile_msg_nif.sv
module tile_msg_nif #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int PHYS_W = 2,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] tile_id,
  input  logic [ID_W-1:0]   task_id,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_idx,
  input  logic              cfg_en,
  input  logic [PHYS_W-1:0] cfg_phys,
  input  logic              err_clr,
  output logic              err_unroutable,
  output logic              err_misroute,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [ID_W-1:0]   msg_dest,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              net_out_valid,
  input  logic              net_out_ready,
  output logic [DATA_W-1:0] net_out_data,
  input  logic              net_in_valid,
  output logic              net_in_ready,
  input  logic [DATA_W-1:0] net_in_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic [ID_W-1:0]   rx_src,
  output logic              rx_last
);

  localparam int ENTRIES  = 1 << ID_W;
  localparam int HDR_USED = PHYS_W + ID_W + LEN_W;

  typedef enum logic [1:0] {T_IDLE, T_HDR, T_BODY, T_DROP} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_BODY, R_SKIP} rx_st_t;

  logic [ENTRIES-1:0] tbl_en;
  logic [PHYS_W-1:0]  tbl_phys [ENTRIES];

  tx_st_t            tx_st;
  logic [LEN_W-1:0]  tx_left;
  logic [DATA_W-1:0] hdr_q;
  logic [DATA_W-1:0] hdr_next;
  logic              hit;

  rx_st_t            rx_st;
  logic [LEN_W-1:0]  rx_left;
  logic [ID_W-1:0]   src_q;
  logic [PHYS_W-1:0] in_dest;
  logic [ID_W-1:0]   in_src;
  logic [LEN_W-1:0]  in_len;

  // translation table, written by the host at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_en <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl_phys[i] <= '0;
    end else if (cfg_we) begin
      tbl_en[cfg_idx]   <= cfg_en;
      tbl_phys[cfg_idx] <= cfg_phys;
    end
  end

  assign hit      = tbl_en[msg_dest];
  assign hdr_next = {{(DATA_W-HDR_USED){1'b0}}, tbl_phys[msg_dest], task_id, msg_len};

  assign msg_ready     = (tx_st == T_IDLE);
  assign net_out_valid = (tx_st == T_HDR) || (tx_st == T_BODY && tx_valid);
  assign net_out_data  = (tx_st == T_HDR) ? hdr_q : tx_data;
  assign tx_ready      = (tx_st == T_BODY && net_out_ready) || (tx_st == T_DROP);

  // send path: lookup once per message, header latched for the whole packet
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_left <= '0;
      hdr_q   <= '0;
    end else begin
      case (tx_st)
        T_IDLE: if (msg_valid) begin
          tx_left <= msg_len;
          hdr_q   <= hdr_next;
          if (hit) tx_st <= T_HDR;
          else if (msg_len != '0) tx_st <= T_DROP;
        end
        T_HDR: if (net_out_ready) tx_st <= (tx_left == '0) ? T_IDLE : T_BODY;
        T_BODY: if (tx_valid && net_out_ready) begin
          tx_left <= tx_left - 1'b1;
          if (tx_left == 1) tx_st <= T_IDLE;
        end
        T_DROP: if (tx_valid) begin
          tx_left <= tx_left - 1'b1;
          if (tx_left == 1) tx_st <= T_IDLE;
        end
        default: tx_st <= T_IDLE;
      endcase
    end
  end

  // receive path
  assign in_len  = net_in_data[LEN_W-1:0];
  assign in_src  = net_in_data[LEN_W+ID_W-1:LEN_W];
  assign in_dest = net_in_data[HDR_USED-1:LEN_W+ID_W];

  assign net_in_ready = (rx_st == R_IDLE) || (rx_st == R_SKIP) || (rx_st == R_BODY && rx_ready);
  assign rx_valid     = (rx_st == R_BODY) && net_in_valid;
  assign rx_data      = net_in_data;
  assign rx_src       = src_q;
  assign rx_last      = (rx_st == R_BODY) && (rx_left == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st   <= R_IDLE;
      rx_left <= '0;
      src_q   <= '0;
    end else begin
      case (rx_st)
        R_IDLE: if (net_in_valid) begin
          rx_left <= in_len;
          src_q   <= in_src;
          if (in_len != '0) rx_st <= (in_dest == tile_id) ? R_BODY : R_SKIP;
        end
        R_BODY: if (net_in_valid && rx_ready) begin
          rx_left <= rx_left - 1'b1;
          if (rx_left == 1) rx_st <= R_IDLE;
        end
        R_SKIP: if (net_in_valid) begin
          rx_left <= rx_left - 1'b1;
          if (rx_left == 1) rx_st <= R_IDLE;
        end
        default: rx_st <= R_IDLE;
      endcase
    end
  end

  // sticky error flags, a new event wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_unroutable <= 1'b0;
      err_misroute   <= 1'b0;
    end else begin
      if (tx_st == T_IDLE && msg_valid && !hit) err_unroutable <= 1'b1;
      else if (err_clr) err_unroutable <= 1'b0;
      if (rx_st == R_IDLE && net_in_valid && in_dest != tile_id) err_misroute <= 1'b1;
      else if (err_clr) err_misroute <= 1'b0;
    end
  end

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_HDR && !net_out_ready) |=> (net_out_valid && $stable(net_out_data))); // R8
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == T_DROP) |-> !net_out_valid); // R3
  AST_UNROUTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unroutable && !err_clr) |=> err_unroutable); // R4
  AST_MISROUTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_misroute && !err_clr) |=> err_misroute); // R4
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_SKIP) |-> !rx_valid); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_last) |=> !rx_valid); // R6

endmodule

// File: tb/tile_msg_nif_test.sv
module tile_msg_nif_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [1:0] tile_id;
  logic [3:0] task_id;
  logic cfg_we, cfg_en, err_clr;
  logic [3:0] cfg_idx;
  logic [1:0] cfg_phys;
  logic err_unroutable, err_misroute;
  logic msg_valid, msg_ready;
  logic [3:0] msg_dest, msg_len;
  logic tx_valid, tx_ready;
  logic [31:0] tx_data;
  logic net_out_valid, net_out_ready;
  logic [31:0] net_out_data;
  logic net_in_valid, net_in_ready;
  logic [31:0] net_in_data;
  logic rx_valid, rx_ready, rx_last;
  logic [31:0] rx_data;
  logic [3:0] rx_src;

  tile_msg_nif uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] got [0:31];
  logic        got_last [0:31];
  logic [3:0]  got_src [0:31];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic en, input logic [1:0] phys);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_en = en; cfg_phys = phys;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  // send one message; returns number of flits seen and payload words consumed
  task automatic send(input logic [3:0] idx, input logic [3:0] len, input logic [31:0] base,
                      input bit bp, input bit mid_wr, input logic [1:0] mid_phys,
                      output int n, output int k);
    logic [31:0] held;
    bit stalled;
    n = 0; k = 0; stalled = 0; held = '0;
    @(negedge clk);
    msg_valid = 1; msg_dest = idx; msg_len = len;
    #1 chk(msg_ready == 1'b1, "R2 msg_ready idle", {31'b0, msg_ready}, 32'd1);
    @(negedge clk);
    msg_valid = 0;
    for (int c = 0; c < 60; c++) begin
      tx_valid = 1; tx_data = base + k;
      net_out_ready = bp ? (c % 3 != 1) : 1'b1;
      cfg_we = 0;
      if (mid_wr && c == 2) begin
        cfg_we = 1; cfg_idx = idx; cfg_en = 1; cfg_phys = mid_phys;
      end
      #1;
      if (stalled) chk(net_out_valid && net_out_data == held, "R8 flit held", net_out_data, held);
      stalled = net_out_valid && !net_out_ready;
      held = net_out_data;
      if (net_out_valid && net_out_ready) begin got[n] = net_out_data; n++; end
      if (tx_valid && tx_ready) k++;
      @(negedge clk);
    end
    tx_valid = 0; net_out_ready = 1; cfg_we = 0;
  endtask

  task automatic check_tx(input logic [3:0] idx, input logic [3:0] len, input logic [31:0] base,
                          input bit en, input logic [1:0] phys, input bit bp, input bit mid_wr,
                          input logic [1:0] mid_phys);
    int n, k;
    logic [31:0] hdr;
    send(idx, len, base, bp, mid_wr, mid_phys, n, k);
    hdr = {22'b0, phys, task_id, len};
    chk(k == int'(len), "R2/R3 payload consumed", k, len);
    if (en) begin
      chk(n == int'(len) + 1, "R2/R9 flit count", n, len + 1);
      if (n == int'(len) + 1) begin
        chk(got[0] == hdr, "R2 header", got[0], hdr);
        for (int j = 1; j <= int'(len); j++)
          chk(got[j] == base + j - 1, "R2 payload", got[j], base + j - 1);
      end
      chk(err_unroutable == 1'b0, "R2 no error", {31'b0, err_unroutable}, 0);
    end else begin
      chk(n == 0, "R3 nothing sent", n, 0);
      chk(err_unroutable == 1'b1, "R3 error set", {31'b0, err_unroutable}, 1);
      pulse_clr();
      #1 chk(err_unroutable == 1'b0, "R4 clear", {31'b0, err_unroutable}, 0);
    end
  endtask

  task automatic recv(input logic [1:0] dest, input logic [3:0] src, input logic [3:0] len,
                      input logic [31:0] base, input bit bp);
    int sent, nr;
    sent = 0; nr = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      net_in_valid = (sent <= int'(len));
      net_in_data  = (sent == 0) ? {22'b0, dest, src, len} : base + sent - 1;
      rx_ready     = bp ? (c % 2 == 0) : 1'b1;
      #1;
      if (rx_valid && rx_ready) begin
        got[nr] = rx_data; got_last[nr] = rx_last; got_src[nr] = rx_src; nr++;
      end
      if (net_in_valid && net_in_ready) sent++;
    end
    @(negedge clk);
    net_in_valid = 0; rx_ready = 1;
    chk(sent == int'(len) + 1, "R6/R7 packet consumed", sent, len + 1);
    if (dest == tile_id) begin
      chk(nr == int'(len), "R6/R9 beats delivered", nr, len);
      for (int j = 0; j < nr && j < int'(len); j++) begin
        chk(got[j] == base + j, "R6/R8 rx data", got[j], base + j);
        chk(got_src[j] == src, "R6 rx_src", {28'b0, got_src[j]}, {28'b0, src});
        chk(got_last[j] == (j == int'(len) - 1), "R6 rx_last", {31'b0, got_last[j]},
            {31'b0, (j == int'(len) - 1)});
      end
      chk(err_misroute == 1'b0, "R6 no misroute", {31'b0, err_misroute}, 0);
    end else begin
      chk(nr == 0, "R7 nothing delivered", nr, 0);
      chk(err_misroute == 1'b1, "R7 misroute set", {31'b0, err_misroute}, 1);
      pulse_clr();
      #1 chk(err_misroute == 1'b0, "R4 misroute clear", {31'b0, err_misroute}, 0);
    end
  endtask

  function automatic bit sw_en(input int i); return (i % 3) != 2; endfunction
  function automatic logic [1:0] sw_phys(input int i); return 2'((i * 3 + 1) % 4); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tile_id = 2'd2; task_id = 4'd9;
    cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_phys = 0; err_clr = 0;
    msg_valid = 0; msg_dest = 0; msg_len = 0;
    tx_valid = 0; tx_data = 0; net_out_ready = 1;
    net_in_valid = 0; net_in_data = 0; rx_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(net_out_valid == 0, "R1 net_out_valid", {31'b0, net_out_valid}, 0);
    chk(rx_valid == 0, "R1 rx_valid", {31'b0, rx_valid}, 0);
    chk(msg_ready == 1, "R1 msg_ready", {31'b0, msg_ready}, 1);
    chk(!err_unroutable && !err_misroute, "R1 flags", {30'b0, err_unroutable, err_misroute}, 0);
    // R1: table empty after reset
    check_tx(4'd5, 4'd3, 32'hB000_0000, 0, 2'd0, 0, 0, 2'd0);

    // sweep all logical numbers
    for (int i = 0; i < 16; i++) cfg_write(4'(i), sw_en(i), sw_phys(i));
    for (int i = 0; i < 16; i++)
      check_tx(4'(i), 4'(i), 32'hA000_0000 + i * 256, sw_en(i), sw_phys(i), 0, 0, 2'd0);

    // R5: write during a packet, then removal
    check_tx(4'd4, 4'd6, 32'hC000_0000, 1, sw_phys(4), 0, 1, 2'd3);
    check_tx(4'd4, 4'd2, 32'hC100_0000, 1, 2'd3, 0, 0, 2'd0);
    cfg_write(4'd4, 1'b0, 2'd0);
    check_tx(4'd4, 4'd2, 32'hC200_0000, 0, 2'd0, 0, 0, 2'd0);

    // R4: new error together with clear leaves flag set
    cfg_write(4'd2, 1'b0, 2'd0);
    @(negedge clk); msg_valid = 1; msg_dest = 4'd2; msg_len = 4'd0; err_clr = 1;
    @(negedge clk); msg_valid = 0; err_clr = 0;
    #1 chk(err_unroutable == 1'b1, "R4 set wins over clear", {31'b0, err_unroutable}, 1);
    pulse_clr();

    // receive sweep
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < 4; l++) begin
        int len;
        len = (l == 0) ? 0 : (l == 1) ? 1 : (l == 2) ? 7 : 15;
        recv(2'(d), 4'(d * 4 + l), 4'(len), 32'hD000_0000 + d * 4096 + l * 256, 0);
      end

    // R8: backpressure on both paths
    for (int i = 0; i < 16; i += 5)
      check_tx(4'(i), 4'(15 - i), 32'hE000_0000 + i * 256, sw_en(i), sw_phys(i), 1, 0, 2'd0);
    recv(2'd2, 4'd7, 4'd15, 32'hF000_0000, 1);
    recv(2'd1, 4'd3, 4'd5, 32'hF100_0000, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule